// File: doc/BRIEF.md
# Square-and-Multiply Modular Exponentiation Sequencer

This block produces a signature value S = D^e mod m. D is a message digest, zero-extended to the operand width. e is a private exponent and m is the modulus. When a start pulse arrives, the block captures all three operands. It walks the exponent from its most significant bit downwards and skips any leading zeros.

At the first set bit, the accumulator is loaded with the base reduced modulo m. Every later bit costs one modular squaring. A set bit adds a modular product with the base. Each of these products is handed to a bit-serial interleaved modular multiplier through a start/done handshake, and the exponent position advances only when that product returns.

At start the result register takes the modulus for one cycle and passes it into the modulus register. It then holds the running value. The completion flag stays high, and the result stays frozen, until the next start. The caller must supply a modulus of at least 2.

Top module: `modexp_seq`

## Requirements
- R1: After reset, `complete` is 0 and `result` is all zeros.
- R2: For a modulus m of 2 or more, the run started by `data_ready` ends with `result` equal to D^e mod m, where D is `digest` with zeros above its width. D may exceed m.
- R3: An exponent of zero gives a result of 1.
- R4: A zero digest with a nonzero exponent gives a result of 0.
- R5: A `data_ready` pulse accepted while idle drives `complete` low at the next clock edge. `complete` stays low until the run finishes.
- R6: While `complete` is high and `data_ready` is low, `complete` stays high and `result` does not change.
- R7: A `data_ready` pulse during a run is ignored, and the run finishes with the value of the operands it started with.
- R8: The operands are captured on the start edge. Changing `digest`, `key` or `modulus` later in the run does not change the result.
- R9: A new product is requested only while the multiplier is idle, and never in two cycles back to back. For a nonzero exponent, `complete` therefore rises no earlier than W cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_ready | input | 1 | Start pulse that captures the operands when idle |
| digest | input | DW | Message digest (base) |
| key | input | W | Exponent |
| modulus | input | W | Modulus, 2 or more |
| result | output | W | Exponentiation result, valid while `complete` is high |
| complete | output | 1 | High once a run has finished, until the next start |

## Verification
A wrong exponent index, a product step that skips a reduction, or a base left unreduced shows up as a wrong `result` at the moment `complete` rises. So every run of a sweep over small moduli, digests at or above the modulus, and dense, sparse and zero exponents is compared with arithmetic done in the bench. A sequencer that loses its state or accepts a second start shows either as a result tied to the wrong operands or as `complete` rising far too early. The cycle count and the restart tests catch this within one run. A broken hold path shows within a few cycles after completion.

// File: rtl/modexp_pkg.sv
package modexp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOADM,
    ST_SCAN,
    ST_ISSUE,
    ST_WAIT
  } me_state_t;

  typedef enum logic [1:0] {
    OP_BASE,
    OP_SQR,
    OP_MUL
  } me_op_t;
endpackage

// File: rtl/mm_step.sv
// One interleaved step: p_out = (2*p_in + bit*b) mod m, with p_in, b < m.
module mm_step #(
  parameter int W = 512
) (
  input  logic [W-1:0] p_in,
  input  logic         bit_in,
  input  logic [W-1:0] b,
  input  logic [W-1:0] m,
  output logic [W-1:0] p_out
);
  localparam int XW = W + 2;

  logic [XW-1:0] t, m1, m2;

  always_comb begin
    m1 = {2'b00, m};
    m2 = {1'b0, m, 1'b0};
    t  = {1'b0, p_in, 1'b0} + (bit_in ? {2'b00, b} : '0);
    if (t >= m2)      p_out = W'(t - m2);
    else if (t >= m1) p_out = W'(t - m1);
    else              p_out = W'(t);
  end
endmodule

// File: rtl/mm_serial.sv
// Bit-serial modular multiplier: p = a * b mod m, scanning a from the MSB.
module mm_serial #(
  parameter int W = 512
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] m,
  output logic [W-1:0] p,
  output logic         done,
  output logic         busy
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  a_sh, b_q, p_next;
  logic [CW-1:0] cnt;

  mm_step #(.W(W)) u_step (
    .p_in  (p),
    .bit_in(a_sh[W-1]),
    .b     (b_q),
    .m     (m),
    .p_out (p_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_sh <= '0;
      b_q  <= '0;
      p    <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        a_sh <= a;
        b_q  <= b;
        p    <= '0;
        cnt  <= CW'(W);
        busy <= 1'b1;
      end else if (busy) begin
        p    <= p_next;
        a_sh <= {a_sh[W-2:0], 1'b0};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/modexp_seq.sv
module modexp_seq #(
  parameter int W  = 512,
  parameter int DW = 160
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          data_ready,
  input  logic [DW-1:0] digest,
  input  logic [W-1:0]  key,
  input  logic [W-1:0]  modulus,
  output logic [W-1:0]  result,
  output logic          complete
);
  import modexp_pkg::*;

  localparam int IW = $clog2(W);

  me_state_t     state;
  me_op_t        op;
  logic [IW-1:0] idx;
  logic [W-1:0]  msg_q, key_q, mod_q, acc;
  logic [W-1:0]  mul_a, mul_b, mul_p;
  logic          mul_start, mul_done, mul_busy, running;

  assign result    = acc;
  assign mul_start = (state == ST_ISSUE);
  assign running   = (state != ST_IDLE);

  always_comb begin
    unique case (op)
      OP_BASE: begin mul_a = msg_q; mul_b = W'(1);  end
      OP_SQR:  begin mul_a = acc;   mul_b = acc;    end
      default: begin mul_a = acc;   mul_b = msg_q;  end
    endcase
  end

  mm_serial #(.W(W)) u_mul (
    .clk  (clk),
    .rst  (rst),
    .start(mul_start),
    .a    (mul_a),
    .b    (mul_b),
    .m    (mod_q),
    .p    (mul_p),
    .done (mul_done),
    .busy (mul_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op       <= OP_BASE;
      idx      <= '0;
      msg_q    <= '0;
      key_q    <= '0;
      mod_q    <= '0;
      acc      <= '0;
      complete <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (data_ready) begin
          acc      <= modulus;        // result register first carries m
          msg_q    <= W'(digest);
          key_q    <= key;
          complete <= 1'b0;
          state    <= ST_LOADM;
        end
        ST_LOADM: begin
          mod_q <= acc;
          acc   <= W'(1);
          idx   <= IW'(W - 1);
          state <= ST_SCAN;
        end
        ST_SCAN: begin
          if (key_q[idx]) begin
            op    <= OP_BASE;
            state <= ST_ISSUE;
          end else if (idx == '0) begin
            complete <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            idx <= idx - 1'b1;
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: if (mul_done) begin
          acc <= mul_p;
          if (op == OP_BASE) msg_q <= mul_p;
          if (op == OP_SQR && key_q[idx]) begin
            op    <= OP_MUL;
            state <= ST_ISSUE;
          end else if (idx == '0) begin
            complete <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            idx   <= idx - 1'b1;
            op    <= OP_SQR;
            state <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/modexp_checks.sv
module modexp_checks #(
  parameter int W = 512
) (
  input logic         clk,
  input logic         rst,
  input logic         data_ready,
  input logic         complete,
  input logic [W-1:0] result,
  input logic [W-1:0] mod_q,
  input logic         mul_start,
  input logic         mul_busy,
  input logic         running
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!complete && result == '0));

  p_result_reduced_r2: assert property (@(posedge clk) disable iff (rst)
    complete |-> (result < mod_q));

  p_no_complete_busy_r5: assert property (@(posedge clk) disable iff (rst)
    running |-> !complete);

  p_start_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (complete && data_ready) |=> !complete);

  p_hold_result_r6: assert property (@(posedge clk) disable iff (rst)
    (complete && !data_ready) |=> (complete && $stable(result)));

  p_req_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
    mul_start |-> !mul_busy);

  p_req_single_r9: assert property (@(posedge clk) disable iff (rst)
    mul_start |=> !mul_start);
endmodule

bind modexp_seq modexp_checks #(.W(W)) u_checks (
  .clk       (clk),
  .rst       (rst),
  .data_ready(data_ready),
  .complete  (complete),
  .result    (result),
  .mod_q     (mod_q),
  .mul_start (mul_start),
  .mul_busy  (mul_busy),
  .running   (running)
);

// File: tb/test_modexp_seq.sv
`timescale 1ns/1ps
module test_modexp_seq;
  localparam int SW = 16, SD = 8, BW = 512, BD = 160;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          s_dr = 1'b0, s_cmp;
  logic [SD-1:0] s_dig = '0;
  logic [SW-1:0] s_key = '0, s_mod = '0, s_res;

  logic          b_dr = 1'b0, b_cmp;
  logic [BD-1:0] b_dig = '0;
  logic [BW-1:0] b_key = '0, b_mod = '0, b_res;

  int nchk = 0, nfail = 0;

  modexp_seq #(.W(SW), .DW(SD)) i_modexp_seq (
    .clk(clk), .rst(rst), .data_ready(s_dr), .digest(s_dig), .key(s_key),
    .modulus(s_mod), .result(s_res), .complete(s_cmp));

  modexp_seq #(.W(BW), .DW(BD)) i_modexp_seq_w512 (
    .clk(clk), .rst(rst), .data_ready(b_dr), .digest(b_dig), .key(b_key),
    .modulus(b_mod), .result(b_res), .complete(b_cmp));

  task automatic chk(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] ref16(input logic [SW-1:0] d, e, m);
    logic [31:0] r, b;
    r = 1;
    b = {16'd0, d} % {16'd0, m};
    for (int i = 0; i < SW; i++) begin
      if (e[i]) r = (r * b) % {16'd0, m};
      b = (b * b) % {16'd0, m};
    end
    return r[SW-1:0];
  endfunction

  function automatic logic [BW-1:0] ref512(input logic [BW-1:0] d, e, m);
    logic [2*BW-1:0] r, b, mm;
    mm = {{BW{1'b0}}, m};
    r  = 1;
    b  = {{BW{1'b0}}, d} % mm;
    for (int i = 0; i < BW; i++) begin
      if (e[i]) r = (r * b) % mm;
      b = (b * b) % mm;
    end
    return r[BW-1:0];
  endfunction

  function automatic logic [SW-1:0] small_mod(input int i);
    case (i)
      0: return 16'd2;     1: return 16'd3;     2: return 16'd7;
      3: return 16'd255;   4: return 16'd256;   5: return 16'd257;
      6: return 16'd1021;  7: return 16'd40961; 8: return 16'd65521;
      default: return 16'd65535;
    endcase
  endfunction

  task automatic start16(input logic [SD-1:0] d, input logic [SW-1:0] e, m);
    @(negedge clk);
    s_dig = d; s_key = e; s_mod = m; s_dr = 1'b1;
    @(negedge clk);
    s_dr = 1'b0;
  endtask

  task automatic wait16(output int n);
    n = 1;
    while (!s_cmp && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run512(input logic [BD-1:0] d, input logic [BW-1:0] e, m, input string req);
    int n;
    @(negedge clk);
    b_dig = d; b_key = e; b_mod = m; b_dr = 1'b1;
    @(negedge clk);
    b_dr = 1'b0;
    chk("R5", {511'd0, b_cmp}, '0);
    n = 1;
    while (!b_cmp && n < 40000) begin
      @(negedge clk);
      n++;
    end
    chk(req, b_res, ref512({{(BW-BD){1'b0}}, d}, e, m));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int n;
    logic [SD-1:0] d;
    logic [SW-1:0] e, m;
    logic [SW-1:0] r0;
    logic [BW-1:0] bm;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state on both configurations
    chk("R1", {495'd0, s_cmp, s_res}, '0);
    chk("R1", {b_cmp, b_res[BW-2:0]}, '0);

    // R2/R3/R4/R9 sweep over the small configuration
    for (int mi = 0; mi < 10; mi++) begin
      for (int k = 0; k < 10; k++) begin
        m = small_mod(mi);
        d = SD'((mi * 37 + k * 91 + 5) % 256);
        case (k)
          0: e = 16'h0000;
          1: e = 16'h0001;
          2: e = 16'hFFFF;
          3: e = 16'h8000;
          4: begin e = 16'h0123; d = '0; end
          default: e = SW'((mi * 4099 + k * 977 + 1) & 16'hFFFF);
        endcase
        start16(d, e, m);
        if (mi + k > 0) chk("R5", {511'd0, s_cmp}, '0);
        wait16(n);
        if (e == '0)      chk("R3", {496'd0, s_res}, {496'd0, 16'd1});
        else if (d == '0) chk("R4", {496'd0, s_res}, '0);
        else              chk("R2", {496'd0, s_res}, {496'd0, ref16({8'd0, d}, e, m)});
        if (e != '0) begin
          nchk++;
          if (n < SW) begin
            nfail++;
            $display("FAIL R9 actual=%0d expected>=%0d", n, SW);
          end
        end
      end
    end

    // R6: hold after completion while inputs move
    r0 = s_res;
    s_dig = 8'hA5; s_key = 16'h7777; s_mod = 16'd999;
    repeat (6) @(negedge clk);
    chk("R6", {495'd0, s_cmp, s_res}, {495'd0, 1'b1, r0});

    // R7/R8: mid-run restart attempt and operand changes are ignored
    start16(8'hC3, 16'h00F3, 16'd40961);
    repeat (4) @(negedge clk);
    s_dig = 8'h11; s_key = 16'hFFFF; s_mod = 16'd7; s_dr = 1'b1;
    @(negedge clk);
    s_dr = 1'b0;
    wait16(n);
    chk("R7", {496'd0, s_res}, {496'd0, ref16(16'h00C3, 16'h00F3, 16'd40961)});
    start16(8'h9E, 16'h0B1D, 16'd65521);
    repeat (3) @(negedge clk);
    s_dig = 8'h01; s_key = 16'h0000; s_mod = 16'd3;
    wait16(n);
    chk("R8", {496'd0, s_res}, {496'd0, ref16(16'h009E, 16'h0B1D, 16'd65521)});

    // Full-width vectors
    bm = {16{32'hF1E2D3C5}};
    run512(160'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321_A5A5_5A5A, 512'd3, bm, "R2");
    run512(160'hFFFF_0000_FFFF_0000_1111_2222_3333_4444_5555_6667, 512'd65537, bm, "R2");
    run512(160'h0BAD_F00D_CAFE_BABE_DEAD_BEEF_0000_1111_2222_3333, '0, bm, "R3");
    run512('0, 512'd5, bm, "R4");
    run512(160'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10_1112_1314,
           512'hDEAD_BEEF, {bm[BW-1:1], 1'b0} ^ 512'h3, "R2");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule